// File: doc/BRIEF.md
# Buck Converter Protection Supervisor

This block sits between the digitized protection comparators of a synchronous buck converter and its gate drivers. It watches five comparator flags: low-side over-current, feedback under-voltage, the rising and falling feedback over-voltage thresholds, and COMP pulled into shutdown. It decides whether the converter runs normally, has its gates overridden, restarts its soft-start, or is latched off.

Over-current events are retried through a fresh soft-start until a parameterized number of them has been seen, and then the converter latches off. Under-voltage latches off immediately, but only once soft-start has finished. Over-voltage overrides the gates with hysteresis and never latches. A shutdown request holds both switches off, and releasing it clears any latched fault and the over-current tally before a new start. The block also samples and clamps the over-current setting code at each start, and reports a trip code of twice the clamped setting.

Top module: `buck_guard`

## Requirements
- R1: Every comparator flag passes two synchronizer flops and counts as valid only after two consecutive high samples. A flag raised before rising edge E0 and held changes the outputs at edge E3. A flag that is high for a single cycle has no effect.
- R2: While `rst` is high: `ss_restart`=1, `hs_off`=1, `ls_off`=1, `ls_on`=0, `fault_latched`=0, `ocp_trip_code`=2*OCSET_MAX. At the first edge after release, soft-start runs with all gate overrides at 0, and the trip code holds twice the sampled setting.
- R3: An over-current event during soft-start or run, while the tally is below OCP_LIMIT-1, forces `hs_off`=`ls_off`=1 and pulses `ss_restart` for exactly one cycle. Soft-start follows on the next cycle.
- R4: The over-current event that brings the tally to OCP_LIMIT sets `fault_latched`=1 with both switches off and no restart pulse.
- R5: Under-voltage has no effect while `ss_done` is low. Once `ss_done` has moved the block to run, under-voltage latches it off (`fault_latched`=1, both switches off).
- R6: In soft-start or run, a valid `ov_rise_cmp` forces `hs_off`=1, `ls_on`=1, `ls_off`=0. The override holds while `ov_fall_cmp` stays valid, even after `ov_rise_cmp` drops, and it ends when `ov_fall_cmp` falls.
- R7: A valid `dis_cmp` holds `hs_off`=`ls_off`=1 and `ls_on`=0, and clears `fault_latched`. Its release produces a one-cycle `ss_restart`, with the over-current tally reset to zero.
- R8: `ocp_trip_code` equals 2*`ocset_code`. When `ocset_code` exceeds OCSET_MAX, or `ocset_open` is 1, it equals 2*OCSET_MAX instead. The setting is sampled only in the restart cycle and held at all other times.
- R9: Once latched, over-current and over-voltage flags are ignored. Only reset or a shutdown cycle leaves the latch.
- R10: `ls_on` and `ls_off` are never both 1. Priority is shutdown, then under-voltage, then over-current, then over-voltage, so that an over-current and an over-voltage arriving together give a restart with both switches off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on reset) |
| ocp_cmp | input | 1 | Low-side drop above the trip level |
| uv_cmp | input | 1 | Feedback below half the reference |
| ov_rise_cmp | input | 1 | Feedback above the rising over-voltage trip |
| ov_fall_cmp | input | 1 | Feedback above the falling over-voltage trip |
| dis_cmp | input | 1 | COMP held below the shutdown level |
| ss_done | input | 1 | Soft-start ramp has reached the reference |
| ocset_code | input | CODE_W | Sampled over-current setting code |
| ocset_open | input | 1 | No setting resistor detected |
| hs_off | output | 1 | Force the high-side switch off |
| ls_off | output | 1 | Force the low-side switch off |
| ls_on | output | 1 | Force the low-side switch on |
| ss_restart | output | 1 | One-cycle request to restart soft-start |
| fault_latched | output | 1 | Converter latched off |
| ocp_trip_code | output | CODE_W+1 | Current-limit trip code, twice the clamped setting |

## Verification
The bench builds the block with CODE_W=8, OCSET_MAX=150 and OCP_LIMIT=2. With a limit of two, a single retry and then the latch-off can both be reached within a few cycles of each other. A 150 ceiling in an 8-bit code places the clamp boundary (149, 150, 151 and above) well inside the input range, so codes on both sides of it can be driven. The filter depth of two keeps every response at a fixed four-edge latency, and a one-cycle glitch is shown to be rejected.

// File: rtl/buck_guard_pkg.sv
package buck_guard_pkg;

  typedef enum logic [2:0] {
    ST_DIS   = 3'd0,
    ST_START = 3'd1,
    ST_SOFT  = 3'd2,
    ST_RUN   = 3'd3,
    ST_LATCH = 3'd4
  } gstate_e;

  localparam int NUM_CMP = 5;
  localparam int CMP_OCP = 0;
  localparam int CMP_UV  = 1;
  localparam int CMP_OVH = 2;
  localparam int CMP_OVL = 3;
  localparam int CMP_DIS = 4;

  typedef struct packed {
    logic hs_off;
    logic ls_off;
    logic ls_on;
  } gate_cmd_t;

  localparam gate_cmd_t GATES_FREE = '{hs_off: 1'b0, ls_off: 1'b0, ls_on: 1'b0};
  localparam gate_cmd_t GATES_OFF  = '{hs_off: 1'b1, ls_off: 1'b1, ls_on: 1'b0};
  localparam gate_cmd_t GATES_OVP  = '{hs_off: 1'b1, ls_off: 1'b0, ls_on: 1'b1};

endpackage

// File: rtl/bg_sync_filter.sv
module bg_sync_filter #(
  parameter int N    = 5,
  parameter int QUAL = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] valid
);

  for (genvar i = 0; i < N; i++) begin : g_ch
    logic s1_q, s2_q;
    logic [QUAL-2:0] past_q;
    logic [QUAL-1:0] win;

    assign win = {past_q, s2_q};
    assign valid[i] = &win;

    always_ff @(posedge clk) begin
      if (rst) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        past_q <= '0;
      end else begin
        s1_q   <= raw[i];
        s2_q   <= s1_q;
        past_q <= win[QUAL-2:0];
      end
    end

    // R1: a valid flag needs the raw input high on two consecutive samples
    assert_two_samples_R1: assert property (@(posedge clk) disable iff (rst)
      valid[i] |-> ($past(raw[i], 2) && $past(raw[i], 3)));
  end

endmodule

// File: rtl/bg_ocset_clamp.sv
module bg_ocset_clamp #(
  parameter int CODE_W   = 8,
  parameter int MAX_CODE = 150
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample,
  input  logic [CODE_W-1:0] code,
  input  logic              open,
  output logic [CODE_W:0]   trip
);

  localparam logic [CODE_W-1:0] MAX_C = CODE_W'(MAX_CODE);

  logic [CODE_W-1:0] eff;

  always_comb begin
    if (open || (code > MAX_C)) eff = MAX_C;
    else                        eff = code;
  end

  always_ff @(posedge clk) begin
    if (rst)         trip <= {MAX_C, 1'b0};
    else if (sample) trip <= {eff, 1'b0};
  end

endmodule

// File: rtl/bg_fault_fsm.sv
module bg_fault_fsm
  import buck_guard_pkg::*;
#(
  parameter int OCP_LIMIT = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      ocp_v,
  input  logic      uv_v,
  input  logic      ovh_v,
  input  logic      ovl_v,
  input  logic      dis_v,
  input  logic      ss_done,
  output gate_cmd_t gate_q,
  output logic      ss_restart_q,
  output logic      fault_q
);

  localparam int CNT_W = $clog2(OCP_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OCP_LIMIT - 1);

  gstate_e          state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovp_q, ovp_d;
  gate_cmd_t        gate_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ovp_d   = ovh_v | (ovp_q & ovl_v);
    unique case (state_q)
      ST_DIS:   begin
        state_d = ST_START;
        cnt_d   = '0;
      end
      ST_START: state_d = ST_SOFT;
      ST_SOFT, ST_RUN: begin
        if (uv_v && (state_q == ST_RUN)) begin
          state_d = ST_LATCH;
        end else if (ocp_v) begin
          cnt_d   = cnt_q + 1'b1;
          state_d = (cnt_q >= LAST) ? ST_LATCH : ST_START;
        end else if ((state_q == ST_SOFT) && ss_done) begin
          state_d = ST_RUN;
        end
      end
      ST_LATCH: state_d = ST_LATCH;
      default:  state_d = ST_LATCH;
    endcase
    if (dis_v) state_d = ST_DIS;

    if ((state_d == ST_SOFT) || (state_d == ST_RUN))
      gate_d = ovp_d ? GATES_OVP : GATES_FREE;
    else
      gate_d = GATES_OFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_START;
      cnt_q        <= '0;
      ovp_q        <= 1'b0;
      gate_q       <= GATES_OFF;
      ss_restart_q <= 1'b1;
      fault_q      <= 1'b0;
    end else begin
      state_q      <= state_d;
      cnt_q        <= cnt_d;
      ovp_q        <= ovp_d;
      gate_q       <= gate_d;
      ss_restart_q <= (state_d == ST_START);
      fault_q      <= (state_d == ST_LATCH);
    end
  end

  // R3: the restart request lasts one cycle
  assert_restart_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    ss_restart_q |=> !ss_restart_q);

  // R5: under-voltage cannot latch during soft-start
  assert_uv_masked_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SOFT && !ocp_v && !dis_v) |=> (state_q != ST_LATCH));

  // R6: over-voltage in run forces high side off, low side on
  assert_ovp_force_R6: assert property (@(posedge clk) disable iff (rst)
    (ovh_v && !dis_v && !uv_v && !ocp_v && state_q == ST_RUN)
      |=> (gate_q.hs_off && gate_q.ls_on && !gate_q.ls_off));

  // R9: a latched fault persists with both switches off until shutdown
  assert_latch_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (fault_q && !dis_v) |=> (fault_q && gate_q.hs_off && gate_q.ls_off && !ss_restart_q));

  // R10: low-side on and off commands never overlap
  assert_low_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(gate_q.ls_on && gate_q.ls_off));

endmodule

// File: rtl/buck_guard.sv
module buck_guard
  import buck_guard_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int OCSET_MAX = 150,
  parameter int OCP_LIMIT = 2,
  parameter int QUAL      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ocp_cmp,
  input  logic              uv_cmp,
  input  logic              ov_rise_cmp,
  input  logic              ov_fall_cmp,
  input  logic              dis_cmp,
  input  logic              ss_done,
  input  logic [CODE_W-1:0] ocset_code,
  input  logic              ocset_open,
  output logic              hs_off,
  output logic              ls_off,
  output logic              ls_on,
  output logic              ss_restart,
  output logic              fault_latched,
  output logic [CODE_W:0]   ocp_trip_code
);

  logic [NUM_CMP-1:0] raw, vld;
  gate_cmd_t          gate;

  always_comb begin
    raw          = '0;
    raw[CMP_OCP] = ocp_cmp;
    raw[CMP_UV]  = uv_cmp;
    raw[CMP_OVH] = ov_rise_cmp;
    raw[CMP_OVL] = ov_fall_cmp;
    raw[CMP_DIS] = dis_cmp;
  end

  bg_sync_filter #(.N(NUM_CMP), .QUAL(QUAL)) u_filt (
    .clk   (clk),
    .rst   (rst),
    .raw   (raw),
    .valid (vld)
  );

  bg_fault_fsm #(.OCP_LIMIT(OCP_LIMIT)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .ocp_v        (vld[CMP_OCP]),
    .uv_v         (vld[CMP_UV]),
    .ovh_v        (vld[CMP_OVH]),
    .ovl_v        (vld[CMP_OVL]),
    .dis_v        (vld[CMP_DIS]),
    .ss_done      (ss_done),
    .gate_q       (gate),
    .ss_restart_q (ss_restart),
    .fault_q      (fault_latched)
  );

  bg_ocset_clamp #(.CODE_W(CODE_W), .MAX_CODE(OCSET_MAX)) u_clamp (
    .clk    (clk),
    .rst    (rst),
    .sample (ss_restart),
    .code   (ocset_code),
    .open   (ocset_open),
    .trip   (ocp_trip_code)
  );

  assign hs_off = gate.hs_off;
  assign ls_off = gate.ls_off;
  assign ls_on  = gate.ls_on;

  // R8: the trip code only moves in the cycle after a restart request
  assert_trip_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !ss_restart |=> $stable(ocp_trip_code));

  // R4: a latched converter has both switches off
  assert_latch_gates_R4: assert property (@(posedge clk) disable iff (rst)
    fault_latched |-> (hs_off && ls_off && !ls_on));

endmodule

// File: tb/sim_buck_guard.sv
`timescale 1ns/1ps
module sim_buck_guard;

  localparam int CODE_W = 8;
  localparam int OMAX   = 150;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ocp_cmp = 0, uv_cmp = 0, ov_rise_cmp = 0, ov_fall_cmp = 0, dis_cmp = 0;
  logic ss_done = 0;
  logic [CODE_W-1:0] ocset_code = 8'd100;
  logic ocset_open = 0;
  logic hs_off, ls_off, ls_on, ss_restart, fault_latched;
  logic [CODE_W:0] ocp_trip_code;

  int nchk = 0;
  int nbad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  buck_guard #(.CODE_W(CODE_W), .OCSET_MAX(OMAX), .OCP_LIMIT(2), .QUAL(2)) u0 (
    .clk(clk), .rst(rst), .ocp_cmp(ocp_cmp), .uv_cmp(uv_cmp),
    .ov_rise_cmp(ov_rise_cmp), .ov_fall_cmp(ov_fall_cmp), .dis_cmp(dis_cmp),
    .ss_done(ss_done), .ocset_code(ocset_code), .ocset_open(ocset_open),
    .hs_off(hs_off), .ls_off(ls_off), .ls_on(ls_on), .ss_restart(ss_restart),
    .fault_latched(fault_latched), .ocp_trip_code(ocp_trip_code)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // gate word: {hs_off, ls_off, ls_on}
  function automatic int gw();
    return {29'd0, hs_off, ls_off, ls_on};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // raise a flag at this negedge, hold it across n rising edges, then drop it
  task automatic pulse(ref logic sig, input int n);
    sig = 1'b1;
    tick(n);
    sig = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    tick(3);
    chk("R2 reset restart", ss_restart, 1);
    chk("R2 reset gates", gw(), 3'b110);
    chk("R2 reset fault", fault_latched, 0);
    chk("R2 reset trip", ocp_trip_code, 2 * OMAX);
    rst = 1'b0;
    tick(1);
    chk("R2 soft gates free", gw(), 0);
    chk("R2 restart dropped", ss_restart, 0);
    chk("R8 trip sampled", ocp_trip_code, 200);
  endtask

  task automatic t_glitch;
    int seen = 0;
    pulse(ocp_cmp, 1);
    for (int i = 0; i < 6; i++) begin
      tick(1);
      if (ss_restart || hs_off) seen = 1;
    end
    chk("R1 single-cycle glitch ignored", seen, 0);
  endtask

  task automatic t_uv_masked;
    int seen = 0;
    uv_cmp = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(1);
      if (fault_latched || hs_off) seen = 1;
    end
    uv_cmp = 1'b0;
    chk("R5 uv masked in soft-start", seen, 0);
    tick(3);
  endtask

  task automatic t_ocp_retry(input string tag);
    pulse(ocp_cmp, 3);
    chk({tag, " R1 no response before E3"}, gw(), 0);
    tick(1);
    chk({tag, " R3 restart pulse"}, ss_restart, 1);
    chk({tag, " R3 both off"}, gw(), 3'b110);
    chk({tag, " R3 no latch"}, fault_latched, 0);
    tick(1);
    chk({tag, " R3 restart one cycle"}, ss_restart, 0);
    chk({tag, " R3 gates released"}, gw(), 0);
  endtask

  task automatic t_ocp_latch;
    pulse(ocp_cmp, 3);
    tick(1);
    chk("R4 latched", fault_latched, 1);
    chk("R4 both off", gw(), 3'b110);
    chk("R4 no restart", ss_restart, 0);
  endtask

  task automatic t_ovp;
    ss_done = 1'b1;
    tick(2);
    ov_fall_cmp = 1'b1;
    pulse(ov_rise_cmp, 3);
    tick(1);
    chk("R6 ovp override", gw(), 3'b101);
    tick(6);
    chk("R6 hysteresis hold", gw(), 3'b101);
    ov_fall_cmp = 1'b0;
    tick(3);
    chk("R6 ovp release", gw(), 0);
  endtask

  task automatic t_uv_run;
    pulse(uv_cmp, 3);
    tick(1);
    chk("R5 uv latch in run", fault_latched, 1);
    chk("R5 uv both off", gw(), 3'b110);
  endtask

  task automatic t_latch_ignore;
    int seen = 0;
    ov_fall_cmp = 1'b1;
    ov_rise_cmp = 1'b1;
    ocp_cmp     = 1'b1;
    for (int i = 0; i < 6; i++) begin
      tick(1);
      if (!fault_latched || gw() != 3'b110 || ss_restart) seen = 1;
    end
    ov_rise_cmp = 1'b0;
    ov_fall_cmp = 1'b0;
    ocp_cmp     = 1'b0;
    chk("R9 latch ignores ocp and ovp", seen, 0);
    tick(3);
  endtask

  // shutdown cycle; expect the new setting to give trip code exp_trip
  task automatic t_dis_cycle(input string tag, input int code, input bit open,
                             input int exp_trip);
    ocset_code = CODE_W'(code);
    ocset_open = open;
    pulse(dis_cmp, 3);
    tick(1);
    chk({tag, " R7 shutdown gates"}, gw(), 3'b110);
    chk({tag, " R7 fault cleared"}, fault_latched, 0);
    tick(2);
    chk({tag, " R7 restart on release"}, ss_restart, 1);
    tick(1);
    chk({tag, " R8 trip code"}, ocp_trip_code, exp_trip);
    ocset_open = 1'b0;
  endtask

  task automatic t_trip_hold;
    ocset_code = 8'd20;
    tick(5);
    chk("R8 trip held between restarts", ocp_trip_code, 300);
  endtask

  task automatic t_priority;
    ov_fall_cmp = 1'b1;
    ov_rise_cmp = 1'b1;
    pulse(ocp_cmp, 3);
    ov_rise_cmp = 1'b0;
    tick(1);
    chk("R10 ocp beats ovp", gw(), 3'b110);
    chk("R10 ocp restart", ss_restart, 1);
    tick(1);
    chk("R10 ovp after restart", gw(), 3'b101);
    ov_fall_cmp = 1'b0;
    tick(4);
    // shutdown together with under-voltage: shutdown wins, no latch
    dis_cmp = 1'b1;
    uv_cmp  = 1'b1;
    tick(4);
    chk("R10 shutdown beats uv", fault_latched, 0);
    chk("R10 shutdown gates", gw(), 3'b110);
    uv_cmp  = 1'b0;
    dis_cmp = 1'b0;
    tick(6);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nbad++;
      nchk++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_glitch();
    t_uv_masked();
    t_ocp_retry("first");
    t_ovp();
    t_uv_run();
    t_latch_ignore();
    t_dis_cycle("after uv", 151, 1'b0, 300);
    t_ocp_retry("tally cleared");
    t_ocp_latch();
    t_dis_cycle("exact max", 150, 1'b0, 300);
    t_dis_cycle("below max", 149, 1'b0, 298);
    t_dis_cycle("open", 10, 1'b1, 300);
    t_trip_hold();
    t_dis_cycle("plain", 100, 1'b0, 200);
    t_priority();
    done = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule